// File: doc/BRIEF.md
# Interrupt Node Request Gating

This block sits between the event pulses of on-chip peripherals and a processor core. It holds a set of interrupt nodes, each with a fixed number of sources. Every source has its own status flag, which any event pulse on that source sets. Each source also has its own event enable. Each node has a node enable, and a global enable covers every node except the non-maskable one. The block drives one request line per node toward the core and takes one acknowledge per node back from it.

A parameter chooses how each node behaves. A hardware-clear node uses its flags as the pending request, and the core's acknowledge clears them. A software-clear node also uses its flags as the request, but ignores the acknowledge, so only a software write clears it. An edge node sends the event pulse itself to the core, after gating, and stores the flag only for software to read. A flag on an edge node that was set while the node was masked never turns into a request later. One node index is non-maskable: it has no node enable, it ignores the global enable, and it still honours its source enables. Every node can be shared: the request is the OR of all sources whose flag is set and whose event is enabled.

Each flag is a two-state machine with states FLAG_IDLE and FLAG_PEND. Transition CAPTURE goes from either state to FLAG_PEND when an event arrives. Transition RELEASE goes from FLAG_PEND to FLAG_IDLE on a clear (an acknowledge on hardware-clear nodes, or a software clear bit) when no event arrives in the same cycle. In every other case the state holds.

Top module: `intr_gate_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all flags, all requests, the global enable, the node enables and the event enables are 0.
- R2: An event pulse on source s of node n sets flag bit n*SRCS+s of `flags_o` in the cycle after the pulse, whatever the enables are.
- R3: On a flag-driven node, `req_o[n]` is 1 exactly when the node enable, the global enable and at least one (flag AND event enable) of that node are all 1. It rises in the cycle after the event.
- R4: An event whose event enable bit is 0 never produces a request, even though its flag is set.
- R5: While the global enable is 0, no node except the non-maskable one requests, and events are still captured into their flags.
- R6: On a hardware-clear node, an acknowledge clears all flags of that node in the next cycle, and the request drops in that same cycle.
- R7: On software-clear and edge nodes, an acknowledge has no effect on the flags. Writing 1 to a bit at address 3 clears that flag.
- R8: On an edge node, the request is a one-cycle pulse in the cycle after an enabled event that arrives while the node and global enables are 1. A flag left set while the node was masked produces no request when the node is enabled again.
- R9: The non-maskable node (index NMI_NODE) requests from any flag whose event is enabled, regardless of its node enable bit and the global enable.
- R10: On a shared node, each source has its own flag, and any one enabled pending source drives the node request.
- R11: When an event and a clear (acknowledge or software) hit the same flag in the same cycle, the flag ends up set.
- R12: Register writes take effect in the next cycle. Address 0 bit 0 is the global enable, address 1 bits [NUM_NODES-1:0] are the node enables, address 2 holds the event enables (bit n*SRCS+s), and address 3 is write-1-to-clear for the flags (same bit order).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_NODES*SRCS | Event pulses, bit n*SRCS+s |
| ack_i | input | NUM_NODES | Acknowledge from the core, one per node |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | NUM_NODES*SRCS | Register write data |
| req_o | output | NUM_NODES | Request to the core, one per node |
| flags_o | output | NUM_NODES*SRCS | Status flags for software |

## Verification
A flag machine stuck in the wrong state shows up on `flags_o` in the very next cycle. On a flag-driven node it also shows up on `req_o`, provided the enables are open. A fault in the edge path only appears as a missing or extra one-cycle pulse in the cycle after the event, so the reference model compares every output on every clock. Mistakes in the gating, such as a global mask that reaches the non-maskable node or a masked edge that gets replayed, are caught the first cycle after the enable changes.

// File: rtl/intr_pkg.sv
package intr_pkg;
    typedef enum logic [1:0] {
        KIND_HWCLR = 2'd0,
        KIND_SWCLR = 2'd1,
        KIND_EDGE  = 2'd2
    } node_kind_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_e;

    localparam logic [1:0] ADDR_GLOBAL = 2'd0;
    localparam logic [1:0] ADDR_NODE   = 2'd1;
    localparam logic [1:0] ADDR_EVENT  = 2'd2;
    localparam logic [1:0] ADDR_CLEAR  = 2'd3;
endpackage

// File: rtl/intr_flag_cell.sv
module intr_flag_cell
    import intr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set_i) state_d = FLAG_PEND;          // CAPTURE
            FLAG_PEND: if (!set_i && clr_i) state_d = FLAG_IDLE; // RELEASE
            default:   state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb pend_o = (state_q == FLAG_PEND);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);
endmodule

// File: rtl/intr_node.sv
module intr_node
    import intr_pkg::*;
#(
    parameter int SRCS   = 2,
    parameter int KIND   = 0,
    parameter bit IS_NMI = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SRCS-1:0] evt_i,
    input  logic [SRCS-1:0] ev_en_i,
    input  logic            node_en_i,
    input  logic            glob_en_i,
    input  logic            ack_i,
    input  logic [SRCS-1:0] sw_clr_i,
    output logic            req_o,
    output logic [SRCS-1:0] flags_o
);
    localparam bit HW_CLEAR = (KIND == int'(KIND_HWCLR));
    localparam bit EDGE     = (KIND == int'(KIND_EDGE));

    logic gate;
    logic [SRCS-1:0] clr;

    always_comb gate = IS_NMI ? 1'b1 : (node_en_i & glob_en_i);

    for (genvar s = 0; s < SRCS; s++) begin : g_src
        always_comb clr[s] = sw_clr_i[s] | (HW_CLEAR & ack_i);
        intr_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (evt_i[s]),
            .clr_i  (clr[s]),
            .pend_o (flags_o[s])
        );
        if (!HW_CLEAR) begin : g_keep
            assert_ack_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (flags_o[s] && ack_i && !sw_clr_i[s]) |=> flags_o[s]);
        end else begin : g_drop
            assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_i && !evt_i[s]) |=> !flags_o[s]);
        end
    end

    if (EDGE) begin : g_edge
        logic pulse_q;
        always_ff @(posedge clk) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= gate & |(evt_i & ev_en_i);
        end
        always_comb req_o = pulse_q;

        assert_edge_from_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
            req_o |-> $past(|(evt_i & ev_en_i)));
    end else begin : g_flag
        always_comb req_o = gate & |(flags_o & ev_en_i);

        if (IS_NMI) begin : g_nmi
            assert_nmi_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (|(flags_o & ev_en_i)) |-> req_o);
        end else begin : g_mask
            assert_global_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !glob_en_i |-> !req_o);
        end
    end
endmodule

// File: rtl/intr_regs.sv
module intr_regs
    import intr_pkg::*;
#(
    parameter int NUM_NODES = 4,
    parameter int NFLAGS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_addr_i,
    input  logic [NFLAGS-1:0]    wr_data_i,
    output logic                 glob_en_o,
    output logic [NUM_NODES-1:0] node_en_o,
    output logic [NFLAGS-1:0]    ev_en_o,
    output logic [NFLAGS-1:0]    sw_clr_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en_o <= 1'b0;
            node_en_o <= '0;
            ev_en_o   <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == ADDR_GLOBAL) glob_en_o <= wr_data_i[0];
            if (wr_addr_i == ADDR_NODE)   node_en_o <= wr_data_i[NUM_NODES-1:0];
            if (wr_addr_i == ADDR_EVENT)  ev_en_o   <= wr_data_i;
        end
    end

    always_comb sw_clr_o = (wr_en_i && wr_addr_i == ADDR_CLEAR) ? wr_data_i : '0;

    assert_write_lands_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_EVENT) |=> (ev_en_o == $past(wr_data_i)));
endmodule

// File: rtl/intr_gate_top.sv
module intr_gate_top
    import intr_pkg::*;
#(
    parameter int NUM_NODES = 4,
    parameter int SRCS      = 2,
    parameter int NMI_NODE  = 3,
    parameter logic [2*NUM_NODES-1:0] NODE_KINDS = 8'b00_10_01_00
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_NODES*SRCS-1:0] evt_i,
    input  logic [NUM_NODES-1:0]      ack_i,
    input  logic                      wr_en_i,
    input  logic [1:0]                wr_addr_i,
    input  logic [NUM_NODES*SRCS-1:0] wr_data_i,
    output logic [NUM_NODES-1:0]      req_o,
    output logic [NUM_NODES*SRCS-1:0] flags_o
);
    localparam int NFLAGS = NUM_NODES * SRCS;

    logic                 glob_en;
    logic [NUM_NODES-1:0] node_en;
    logic [NFLAGS-1:0]    ev_en;
    logic [NFLAGS-1:0]    sw_clr;

    intr_regs #(.NUM_NODES(NUM_NODES), .NFLAGS(NFLAGS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .glob_en_o (glob_en),
        .node_en_o (node_en),
        .ev_en_o   (ev_en),
        .sw_clr_o  (sw_clr)
    );

    for (genvar n = 0; n < NUM_NODES; n++) begin : g_node
        intr_node #(
            .SRCS   (SRCS),
            .KIND   (int'(NODE_KINDS[2*n +: 2])),
            .IS_NMI (n == NMI_NODE)
        ) u_node (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_i[n*SRCS +: SRCS]),
            .ev_en_i   (ev_en[n*SRCS +: SRCS]),
            .node_en_i (node_en[n]),
            .glob_en_i (glob_en),
            .ack_i     (ack_i[n]),
            .sw_clr_i  (sw_clr[n*SRCS +: SRCS]),
            .req_o     (req_o[n]),
            .flags_o   (flags_o[n*SRCS +: SRCS])
        );
    end

    assert_disabled_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_en == '0) |-> (req_o == '0));
endmodule

// File: tb/test_intr_gate_top.sv
module test_intr_gate_top;
    localparam int CLK_PERIOD = 10;
    localparam int NN = 4;
    localparam int SR = 2;
    localparam int NF = NN * SR;
    localparam int NMI = 3;
    localparam int KIND [NN] = '{0, 1, 2, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NF-1:0] evt_i = '0;
    logic [NN-1:0] ack_i = '0;
    logic wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = '0;
    logic [NF-1:0] wr_data_i = '0;
    logic [NN-1:0] req_o;
    logic [NF-1:0] flags_o;

    int checks = 0;
    int errors = 0;

    bit m_glob;
    bit [NN-1:0] m_nen;
    bit [NF-1:0] m_een;
    bit [NF-1:0] m_flag;
    bit [NN-1:0] m_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_gate_top i_intr_gate_top (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ack_i(ack_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .req_o(req_o), .flags_o(flags_o)
    );

    task automatic compare(input string tag);
        checks++;
        if (req_o !== m_req) begin
            errors++;
            $display("FAIL %s req actual=%b expected=%b", tag, req_o, m_req);
        end
        checks++;
        if (flags_o !== m_flag) begin
            errors++;
            $display("FAIL %s flags actual=%b expected=%b", tag, flags_o, m_flag);
        end
    endtask

    function automatic bit gate_of(int n, bit g, bit [NN-1:0] ne);
        return (n == NMI) ? 1'b1 : (ne[n] && g);
    endfunction

    task automatic step(input logic [NF-1:0] ev, input logic [NN-1:0] ak,
                        input bit we, input logic [1:0] ad, input logic [NF-1:0] dt,
                        input string tag);
        bit [NF-1:0] nf;
        bit [NN-1:0] pulse;
        evt_i = ev; ack_i = ak; wr_en_i = we; wr_addr_i = ad; wr_data_i = dt;
        for (int f = 0; f < NF; f++) begin
            bit clr;
            clr = (KIND[f / SR] == 0 && ak[f / SR]) || (we && ad == 2'd3 && dt[f]);
            nf[f] = ev[f] ? 1'b1 : (clr ? 1'b0 : m_flag[f]);
        end
        for (int n = 0; n < NN; n++) begin
            bit any;
            any = 1'b0;
            for (int s = 0; s < SR; s++) any |= ev[n*SR+s] & m_een[n*SR+s];
            pulse[n] = (KIND[n] == 2) && gate_of(n, m_glob, m_nen) && any;
        end
        if (we && ad == 2'd0) m_glob = dt[0];
        if (we && ad == 2'd1) m_nen = dt[NN-1:0];
        if (we && ad == 2'd2) m_een = dt;
        m_flag = nf;
        for (int n = 0; n < NN; n++) begin
            bit any;
            any = 1'b0;
            for (int s = 0; s < SR; s++) any |= m_flag[n*SR+s] & m_een[n*SR+s];
            m_req[n] = (KIND[n] == 2) ? pulse[n] : (gate_of(n, m_glob, m_nen) && any);
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step('0, '0, 1'b0, 2'd0, '0, tag);
    endtask

    task automatic wr(input logic [1:0] ad, input logic [NF-1:0] dt, input string tag);
        step('0, '0, 1'b1, ad, dt, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_glob = 0; m_nen = '0; m_een = '0; m_flag = '0; m_req = '0;
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");

        // events with everything disabled: capture only
        step(8'hFF, '0, 1'b0, 2'd0, '0, "R2 R4 R5 capture while masked");
        idle("R4 no request");
        wr(2'd3, 8'hFF, "R7 R12 software clear all");

        // open enables
        wr(2'd2, 8'hFF, "R12 event enables");
        wr(2'd1, 4'hF, "R12 node enables");
        wr(2'd0, 8'h01, "R12 global enable");
        idle("R12 settle");

        // hardware-clear node 0
        step(8'h01, '0, 1'b0, 2'd0, '0, "R3 node0 event");
        idle("R3 node0 holds");
        step('0, 4'h1, 1'b0, 2'd0, '0, "R6 node0 ack");
        idle("R6 node0 cleared");

        // software-clear node 1
        step(8'h04, '0, 1'b0, 2'd0, '0, "R3 node1 event");
        step('0, 4'h2, 1'b0, 2'd0, '0, "R7 node1 ack ignored");
        idle("R7 node1 still pending");
        wr(2'd3, 8'h04, "R7 node1 software clear");

        // edge node 2
        step(8'h10, '0, 1'b0, 2'd0, '0, "R8 edge event");
        idle("R8 pulse ends, flag kept");
        step('0, 4'h4, 1'b0, 2'd0, '0, "R7 edge ack ignored");
        wr(2'd3, 8'h10, "R7 edge clear");

        // masked edge and masked flag, then re-enable
        wr(2'd0, 8'h00, "R5 global off");
        step(8'h21, '0, 1'b0, 2'd0, '0, "R5 R8 events while masked");
        idle("R5 no requests");
        wr(2'd0, 8'h01, "R3 R8 global on again");
        idle("R8 no replay of edge");
        wr(2'd3, 8'hFF, "R7 clear all");

        // node enable off only on node 2
        wr(2'd1, 4'hB, "R12 node2 disabled");
        step(8'h10, '0, 1'b0, 2'd0, '0, "R8 edge masked by node enable");
        wr(2'd1, 4'hF, "R8 node2 re-enabled");
        idle("R8 still no replay");
        wr(2'd3, 8'h10, "R7 clear edge flag");

        // non-maskable node
        wr(2'd0, 8'h00, "R9 global off");
        wr(2'd1, 4'h0, "R9 node enables off");
        step(8'h40, '0, 1'b0, 2'd0, '0, "R9 nmi event");
        step('0, 4'h8, 1'b0, 2'd0, '0, "R6 R9 nmi ack");
        wr(2'd2, 8'hBF, "R9 nmi src0 event disabled");
        step(8'h40, '0, 1'b0, 2'd0, '0, "R4 R9 disabled nmi source");
        step(8'h80, '0, 1'b0, 2'd0, '0, "R9 R10 nmi src1");
        idle("R10 both nmi flags");
        step('0, 4'h8, 1'b0, 2'd0, '0, "R6 nmi ack clears both");

        // shared node 0 with one source disabled
        wr(2'd0, 8'h01, "R10 global on");
        wr(2'd1, 4'hF, "R10 nodes on");
        wr(2'd2, 8'hFE, "R10 node0 src0 disabled");
        step(8'h01, '0, 1'b0, 2'd0, '0, "R4 R10 disabled source only");
        step(8'h02, '0, 1'b0, 2'd0, '0, "R10 other source requests");
        wr(2'd2, 8'hFF, "R10 src0 re-enabled, flag drives");
        wr(2'd3, 8'h02, "R10 clear src1 only");
        wr(2'd3, 8'h01, "R10 clear src0");

        // set beats clear
        step(8'h04, '0, 1'b1, 2'd3, 8'h04, "R11 event vs software clear");
        idle("R11 flag kept");
        step(8'h01, 4'h1, 1'b0, 2'd0, '0, "R11 event vs ack");
        idle("R11 flag kept after ack");
        step('0, 4'h1, 1'b1, 2'd3, 8'h04, "R6 R7 clear both");

        // reset again
        step(8'hFF, '0, 1'b0, 2'd0, '0, "R2 all events");
        rst_n = 1'b0;
        m_glob = 0; m_nen = '0; m_een = '0; m_flag = '0; m_req = '0;
        @(negedge clk);
        compare("R1 re-reset");
        rst_n = 1'b1;
        idle("R1 after re-reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule